// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is a target on a two-wire serial bus (I2C-style) that gives a host access to a small bank of 8-bit configuration and status registers. Seven strap inputs set its bus address. Both bus lines are first synchronised to the system clock and then passed through a majority-free persistence filter. A level change reaches the protocol logic only after it has been seen on three consecutive system clocks. All protocol decisions use these filtered lines. The open-drain data line is modelled as an enable that pulls the line low.

A host selects the target with a write-addressed byte. The first byte that follows becomes the register pointer. Every later byte in that transfer is stored at the pointer, and the pointer then advances. To read, the host sets the pointer in this way, issues a repeated START with the read bit set, and clocks out bytes. The pointer advances after each byte it reads. The register bank has the following contents:

- a read-only identity byte;
- a status byte that follows a live input;
- a control byte with a self-clearing reset request and a power-down request that is ORed with a pin;
- general configuration bytes;
- counter windows that emit a one-cycle clear strobe when they are read.

Top module: `i2c_cfg_target`

## Requirements
- R1: A transfer is accepted only when the seven bits after START equal `dev_addr_i` (MSB first). The eighth bit selects the direction: 1 is read and 0 is write. The target pulls SDA low in the ninth clock of a matching address byte and of every byte it receives. On a non-matching address it never drives SDA, and the bytes that follow change nothing.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Before a START, the target neither acknowledges nor drives SDA. After reset, all outputs are zero.
- R3: In a write-addressed transfer, the first byte loads the register pointer, and each later byte is written to the register the pointer selects.
- R4: The pointer advances by one after every data byte, whether that byte was written or read.
- R5: After a repeated START with the read bit set, reads begin at the pointer loaded earlier.
- R6: A pulse on SCL or SDA that is shorter than three system clocks has no effect. Write data is taken on the filtered rising SCL edge. Read data and acknowledge changes happen only after a filtered falling SCL edge, which means only while SCL is low.
- R7: Register 0x02 bit 4 is a reset request that drives `core_rst_o`. A write sets it. It clears itself on the clock after `rst_done_i` is high, unless a write to 0x02 occurs in that same cycle.
- R8: `pd_o` is register 0x02 bit 5 ORed with `pd_pin_i`. Register access keeps working while `pd_o` is high.
- R9: Register 0x00 reads as {ID_NIB, REV_NIB}, with ID in bits 7:4, and writes to it are ignored. Register 0x01 reads `act_i` in bit 0 and zero elsewhere, and it is also read-only.
- R10: Registers 0x03 and 0x04 are read/write and appear on `cfg_o[7:0]` and `cfg_o[15:8]`. Registers 0x05 to 0x07 read `cnt_i` bytes 0 to 2. Reading one of them pulses the matching `clr_o` bit for exactly one clock after the byte is sent.
- R11: When the host does not acknowledge a read byte, the target stops driving SDA until the next START.
- R12: Addresses beyond 0x07 read as 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| dev_addr_i | input | 7 | Strapped bus address |
| pd_pin_i | input | 1 | External power-down request |
| act_i | input | 1 | Live status bit shown in register 0x01 |
| rst_done_i | input | 1 | Internal reset has finished |
| cnt_i | input | 24 | Three counter bytes, byte 0 at 0x05 |
| ctrl_o | output | 8 | Control register contents |
| pd_o | output | 1 | Combined power-down |
| core_rst_o | output | 1 | Pending reset request |
| cfg_o | output | 16 | Configuration bytes, 0x03 in the low byte |
| clr_o | output | 3 | Clear strobes for the counter windows |

## Verification
The properties assume a well-formed host. SCL stays high and low for much longer than the filter delay, the host changes SDA only while SCL is low except at START and STOP, and it never issues START or STOP while the target is pulling SDA low. The bench master holds each quarter bit for ten system clocks and releases SDA in every acknowledge and read slot. Its glitch pulses last two clocks, which is below the filter's persistence. The bench drives `rst_done_i` for a single clock with no write to 0x02 in that cycle, and it moves `pd_pin_i` only between transfers.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_e;

    typedef struct packed {
        bus_state_e state;
        logic [7:0] shreg;
        logic [2:0] bitcnt;
        logic       rw;
        logic       ptr_phase;
        logic       ack_drv;
        logic       nack;
        logic       oe;
        logic [7:0] ptr;
        logic       scl_p;
        logic       sda_p;
    } proto_s;

    localparam proto_s PROTO_RST = '{
        state:     ST_IDLE,
        shreg:     8'h00,
        bitcnt:    3'd0,
        rw:        1'b0,
        ptr_phase: 1'b0,
        ack_drv:   1'b0,
        nack:      1'b0,
        oe:        1'b0,
        ptr:       8'h00,
        scl_p:     1'b1,
        sda_p:     1'b1
    };

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int NLINES      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] raw_i,
    output logic [NLINES-1:0] filt_o
);

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] sync_d, sync_q;
        logic [FILT_LEN-1:0]    win_d, win_q;
        logic                   lvl_d, lvl_q;

        always_comb begin
            sync_d = {sync_q[SYNC_STAGES-2:0], raw_i[g]};
            win_d  = {win_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            lvl_d  = lvl_q;
            if (&win_q) begin
                lvl_d = 1'b1;
            end else if (~|win_q) begin
                lvl_d = 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q <= '1;
                win_q  <= '1;
                lvl_q  <= 1'b1;
            end else begin
                sync_q <= sync_d;
                win_q  <= win_d;
                lvl_q  <= lvl_d;
            end
        end

        assign filt_o[g] = lvl_q;
    end

endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs #(
    parameter int         NCFG    = 2,
    parameter int         NCNT    = 3,
    parameter logic [3:0] ID_NIB  = 4'h7,
    parameter logic [3:0] REV_NIB = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wdata_i,
    input  logic              rd_done_i,
    input  logic              act_i,
    input  logic              rst_done_i,
    input  logic              pd_pin_i,
    input  logic [NCNT*8-1:0] cnt_i,
    output logic [7:0]        rdata_o,
    output logic [7:0]        ctrl_o,
    output logic [NCFG*8-1:0] cfg_o,
    output logic [NCNT-1:0]   clr_o,
    output logic              pd_o,
    output logic              core_rst_o
);

    localparam int CTRL_ADDR = 2;
    localparam int CFG_BASE  = 3;
    localparam int CNT_BASE  = CFG_BASE + NCFG;
    localparam int RST_BIT   = 4;
    localparam int PD_BIT    = 5;

    logic [7:0]            ctrl_d, ctrl_q;
    logic [NCFG-1:0][7:0]  cfg_d, cfg_q;
    logic [NCNT-1:0]       clr_d, clr_q;

    always_comb begin
        rdata_o = 8'h00;
        if (addr_i == 8'h00) rdata_o = {ID_NIB, REV_NIB};
        if (addr_i == 8'h01) rdata_o = {7'b0, act_i};
        if (addr_i == 8'(CTRL_ADDR)) rdata_o = ctrl_q;
        for (int i = 0; i < NCFG; i++) begin
            if (addr_i == 8'(CFG_BASE + i)) rdata_o = cfg_q[i];
        end
        for (int i = 0; i < NCNT; i++) begin
            if (addr_i == 8'(CNT_BASE + i)) rdata_o = cnt_i[i*8 +: 8];
        end
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (rst_done_i) ctrl_d[RST_BIT] = 1'b0;
        if (wr_en_i && addr_i == 8'(CTRL_ADDR)) ctrl_d = wdata_i;
        cfg_d = cfg_q;
        for (int i = 0; i < NCFG; i++) begin
            if (wr_en_i && addr_i == 8'(CFG_BASE + i)) cfg_d[i] = wdata_i;
        end
        for (int i = 0; i < NCNT; i++) begin
            clr_d[i] = rd_done_i && (addr_i == 8'(CNT_BASE + i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= 8'h00;
            cfg_q  <= '0;
            clr_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            cfg_q  <= cfg_d;
            clr_q  <= clr_d;
        end
    end

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg_out
        assign cfg_o[g*8 +: 8] = cfg_q[g];
    end

    assign ctrl_o     = ctrl_q;
    assign clr_o      = clr_q;
    assign pd_o       = ctrl_q[PD_BIT] | pd_pin_i;
    assign core_rst_o = ctrl_q[RST_BIT];

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_cfg_pkg::*;
#(
    parameter int         NCFG        = 2,
    parameter int         NCNT        = 3,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter logic [3:0] ID_NIB      = 4'h7,
    parameter logic [3:0] REV_NIB     = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [6:0]        dev_addr_i,
    input  logic              pd_pin_i,
    input  logic              act_i,
    input  logic              rst_done_i,
    input  logic [NCNT*8-1:0] cnt_i,
    output logic [7:0]        ctrl_o,
    output logic              pd_o,
    output logic              core_rst_o,
    output logic [NCFG*8-1:0] cfg_o,
    output logic [NCNT-1:0]   clr_o
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] filt;
    logic              scl_f, sda_f;
    proto_s            st_d, st_q;
    logic              scl_rise, scl_fall, start_c, stop_c;
    logic              wr_en, rd_done, byte_inc;
    logic [7:0]        rdata, wdata;
    bus_state_e        cur_state;
    logic [7:0]        cur_ptr;

    i2c_line_filter #(
        .NLINES     (NLINES),
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({sda_i, scl_i}),
        .filt_o(filt)
    );

    assign scl_f    = filt[0];
    assign sda_f    = filt[1];
    assign scl_rise = scl_f & ~st_q.scl_p;
    assign scl_fall = ~scl_f & st_q.scl_p;
    assign start_c  = scl_f & st_q.scl_p & st_q.sda_p & ~sda_f;
    assign stop_c   = scl_f & st_q.scl_p & ~st_q.sda_p & sda_f;
    assign wdata    = {st_q.shreg[6:0], sda_f};

    i2c_cfg_regs #(
        .NCFG   (NCFG),
        .NCNT   (NCNT),
        .ID_NIB (ID_NIB),
        .REV_NIB(REV_NIB)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (st_q.ptr),
        .wr_en_i   (wr_en),
        .wdata_i   (wdata),
        .rd_done_i (rd_done),
        .act_i     (act_i),
        .rst_done_i(rst_done_i),
        .pd_pin_i  (pd_pin_i),
        .cnt_i     (cnt_i),
        .rdata_o   (rdata),
        .ctrl_o    (ctrl_o),
        .cfg_o     (cfg_o),
        .clr_o     (clr_o),
        .pd_o      (pd_o),
        .core_rst_o(core_rst_o)
    );

    always_comb begin
        st_d       = st_q;
        st_d.scl_p = scl_f;
        st_d.sda_p = sda_f;
        wr_en      = 1'b0;
        rd_done    = 1'b0;
        byte_inc   = 1'b0;
        if (start_c) begin
            st_d.state   = ST_ADDR;
            st_d.bitcnt  = 3'd0;
            st_d.oe      = 1'b0;
            st_d.ack_drv = 1'b0;
        end else if (stop_c) begin
            st_d.state = ST_IDLE;
            st_d.oe    = 1'b0;
        end else begin
            case (st_q.state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        st_d.shreg  = wdata;
                        st_d.bitcnt = st_q.bitcnt + 3'd1;
                        if (st_q.bitcnt == 3'd7) begin
                            if (st_q.shreg[6:0] == dev_addr_i) begin
                                st_d.state     = ST_ADDR_ACK;
                                st_d.rw        = sda_f;
                                st_d.ptr_phase = ~sda_f;
                                st_d.ack_drv   = 1'b0;
                            end else begin
                                st_d.state = ST_IDLE;
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_RX_ACK: begin
                    if (scl_fall) begin
                        if (!st_q.ack_drv) begin
                            st_d.oe      = 1'b1;
                            st_d.ack_drv = 1'b1;
                        end else begin
                            st_d.ack_drv = 1'b0;
                            st_d.bitcnt  = 3'd0;
                            if (st_q.state == ST_ADDR_ACK && st_q.rw) begin
                                st_d.state = ST_TX;
                                st_d.shreg = rdata;
                                st_d.oe    = ~rdata[7];
                            end else begin
                                st_d.state = ST_RX;
                                st_d.oe    = 1'b0;
                            end
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        st_d.shreg  = wdata;
                        st_d.bitcnt = st_q.bitcnt + 3'd1;
                        if (st_q.bitcnt == 3'd7) begin
                            st_d.state   = ST_RX_ACK;
                            st_d.ack_drv = 1'b0;
                            if (st_q.ptr_phase) begin
                                st_d.ptr       = wdata;
                                st_d.ptr_phase = 1'b0;
                            end else begin
                                wr_en    = 1'b1;
                                byte_inc = 1'b1;
                                st_d.ptr = st_q.ptr + 8'd1;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (st_q.bitcnt == 3'd7) begin
                            st_d.state = ST_TX_ACK;
                            st_d.oe    = 1'b0;
                            rd_done    = 1'b1;
                            byte_inc   = 1'b1;
                            st_d.ptr   = st_q.ptr + 8'd1;
                        end else begin
                            st_d.shreg  = {st_q.shreg[6:0], 1'b0};
                            st_d.oe     = ~st_q.shreg[6];
                            st_d.bitcnt = st_q.bitcnt + 3'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        st_d.nack = sda_f;
                    end
                    if (scl_fall) begin
                        if (st_q.nack) begin
                            st_d.state = ST_IDLE;
                            st_d.oe    = 1'b0;
                        end else begin
                            st_d.state  = ST_TX;
                            st_d.shreg  = rdata;
                            st_d.oe     = ~rdata[7];
                            st_d.bitcnt = 3'd0;
                        end
                    end
                end
                default: begin
                    st_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PROTO_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o  = st_q.oe;
    assign cur_state = st_q.state;
    assign cur_ptr   = st_q.ptr;

endmodule

// File: rtl/i2c_cfg_checker.sv
module i2c_cfg_checker
    import i2c_cfg_pkg::*;
#(
    parameter int NCNT = 3
) (
    input logic            clk,
    input logic            rst_n,
    input bus_state_e      state,
    input logic            sda_oe,
    input logic [NCNT-1:0] clr,
    input logic            rd_done,
    input logic            pd_pin,
    input logic            pd,
    input logic            core_rst,
    input logic            rst_done,
    input logic            wr_en,
    input logic            byte_inc,
    input logic [7:0]      ptr
);

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_inc |=> (ptr == $past(ptr) + 8'd1)); // R4

    AST_RST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (core_rst && rst_done && !wr_en) |=> !core_rst); // R7

    AST_PD_PIN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pd_pin |-> pd); // R8

    AST_CLR_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr)); // R10

    AST_CLR_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |-> $past(rd_done)); // R10

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> (clr == '0)); // R10

endmodule

bind i2c_cfg_target i2c_cfg_checker #(.NCNT(NCNT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (cur_state),
    .sda_oe  (sda_oe_o),
    .clr     (clr_o),
    .rd_done (rd_done),
    .pd_pin  (pd_pin_i),
    .pd      (pd_o),
    .core_rst(core_rst_o),
    .rst_done(rst_done_i),
    .wr_en   (wr_en),
    .byte_inc(byte_inc),
    .ptr     (cur_ptr)
);

// File: tb/test_i2c_cfg_target.sv
module test_i2c_cfg_target;

    localparam int         Q      = 10;
    localparam logic [6:0] DEV    = 7'h4B;
    localparam logic [7:0] ID_RD  = 8'h72;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_line;
    logic        sda_oe_o;
    logic        pd_pin = 1'b0;
    logic        act = 1'b0;
    logic        rst_done = 1'b0;
    logic [23:0] cnt = 24'h0;
    logic [7:0]  ctrl_o;
    logic        pd_o, core_rst_o;
    logic [15:0] cfg_o;
    logic [2:0]  clr_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit settled = 1'b0;
    bit prev_oe = 1'b0;
    int clr_seen [3];

    logic [7:0] mctrl = 8'h00;
    logic [7:0] mcfg [2] = '{8'h00, 8'h00};

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe_o;

    i2c_cfg_target i_i2c_cfg_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe_o  (sda_oe_o),
        .dev_addr_i(DEV),
        .pd_pin_i  (pd_pin),
        .act_i     (act),
        .rst_done_i(rst_done),
        .cnt_i     (cnt),
        .ctrl_o    (ctrl_o),
        .pd_o      (pd_o),
        .core_rst_o(core_rst_o),
        .cfg_o     (cfg_o),
        .clr_o     (clr_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act_v,
                       input logic [31:0] exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act_v, exp_v, $time);
        end
    endtask

    function automatic logic [7:0] mdl_read(input logic [7:0] a);
        case (a)
            8'h00: return ID_RD;
            8'h01: return {7'b0, act};
            8'h02: return mctrl;
            8'h03: return mcfg[0];
            8'h04: return mcfg[1];
            8'h05: return cnt[7:0];
            8'h06: return cnt[15:8];
            8'h07: return cnt[23:16];
            default: return 8'h00;
        endcase
    endfunction

    task automatic mdl_write(input logic [7:0] a, input logic [7:0] v);
        if (a == 8'h02) mctrl = v;
        if (a == 8'h03) mcfg[0] = v;
        if (a == 8'h04) mcfg[1] = v;
    endtask

    // per-clock comparison against the model: configuration outputs, power-down, drive timing
    always @(negedge clk) begin
        if (rst_n && settled) begin
            chk(cfg_o == {mcfg[1], mcfg[0]}, "R10 cfg_o", 32'(cfg_o), 32'({mcfg[1], mcfg[0]}));
            chk(pd_o == (mctrl[5] | pd_pin), "R8 pd_o", 32'(pd_o), 32'(mctrl[5] | pd_pin));
        end
        if (rst_n && (sda_oe_o != prev_oe)) begin
            chk(!m_scl, "R6 drive change while SCL low", 32'(m_scl), 32'd0);
        end
        prev_oe = sda_oe_o;
        for (int i = 0; i < 3; i++) begin
            if (clr_o[i]) clr_seen[i]++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1;
            if (glitch && i == 4) begin
                tick(Q);
                m_scl = 1'b0; tick(2);
                m_scl = 1'b1; tick(Q);
                m_sda = ~b[i]; tick(2);
                m_sda = b[i]; tick(Q);
            end else begin
                tick(2 * Q);
            end
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic ack_bit, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = ack_bit; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic reg_write(input logic [7:0] p, input logic [7:0] data[$], input bit glitch);
        logic ack;
        settled = 1'b0;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, ack);
        chk(ack == 1'b0, "R1 address ack", 32'(ack), 32'd0);
        send_byte(p, 1'b0, ack);
        chk(ack == 1'b0, "R3 pointer ack", 32'(ack), 32'd0);
        foreach (data[k]) begin
            send_byte(data[k], glitch && k == 0, ack);
            chk(ack == 1'b0, "R1 data ack", 32'(ack), 32'd0);
            mdl_write(p + 8'(k), data[k]);
        end
        bus_stop();
        tick(20);
        settled = 1'b1;
    endtask

    task automatic reg_read_chk(input logic [7:0] p, input int n, input string req);
        logic       ack;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, ack);
        send_byte(p, 1'b0, ack);
        bus_start();
        send_byte({DEV, 1'b1}, 1'b0, ack);
        chk(ack == 1'b0, "R5 read address ack", 32'(ack), 32'd0);
        for (int k = 0; k < n; k++) begin
            recv_byte((k == n - 1) ? 1'b1 : 1'b0, b);
            chk(b == mdl_read(p + 8'(k)), req, 32'(b), 32'(mdl_read(p + 8'(k))));
        end
        bus_stop();
        tick(20);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic       ack;
        logic [7:0] b;
        for (int i = 0; i < 3; i++) clr_seen[i] = 0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R2: reset state
        chk(sda_oe_o == 1'b0, "R2 reset sda_oe", 32'(sda_oe_o), 32'd0);
        chk(cfg_o == 16'h0 && ctrl_o == 8'h0, "R2 reset regs", 32'({ctrl_o, cfg_o}), 32'd0);
        chk(pd_o == 1'b0 && core_rst_o == 1'b0 && clr_o == 3'b0, "R2 reset flags",
            32'({pd_o, core_rst_o, clr_o}), 32'd0);
        settled = 1'b1;

        // R2: a byte clocked without START is not acknowledged
        m_scl = 1'b0; tick(Q);
        send_byte({DEV, 1'b0}, 1'b0, ack);
        chk(ack == 1'b1, "R2 no ack before START", 32'(ack), 32'd1);
        m_scl = 1'b1; tick(Q);

        // R3 R4: pointer load then two written bytes
        reg_write(8'h03, '{8'hA5, 8'h3C}, 1'b0);
        chk(cfg_o == 16'h3CA5, "R4 write auto-increment", 32'(cfg_o), 32'h3CA5);

        // R1: foreign address is not acknowledged and changes nothing
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, 1'b0, ack);
        chk(ack == 1'b1, "R1 foreign address nack", 32'(ack), 32'd1);
        send_byte(8'h03, 1'b0, ack);
        send_byte(8'hEE, 1'b0, ack);
        chk(ack == 1'b1, "R1 foreign data nack", 32'(ack), 32'd1);
        bus_stop();
        tick(20);
        chk(cfg_o == 16'h3CA5, "R1 foreign write ignored", 32'(cfg_o), 32'h3CA5);

        // R5 R4: repeated-start read from loaded pointer, two bytes
        reg_read_chk(8'h03, 2, "R5 read from pointer");

        // R11: after NACK the target does not drive the next byte
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, ack);
        send_byte(8'h04, 1'b0, ack);
        bus_start();
        send_byte({DEV, 1'b1}, 1'b0, ack);
        recv_byte(1'b1, b);
        chk(b == 8'h3C, "R11 byte before nack", 32'(b), 32'h3C);
        recv_byte(1'b1, b);
        chk(b == 8'hFF, "R11 released after nack", 32'(b), 32'hFF);
        bus_stop();
        tick(20);

        // R9: identity is read-only, status follows act_i
        reg_write(8'h00, '{8'hFF}, 1'b0);
        act = 1'b1;
        reg_read_chk(8'h00, 2, "R9 identity and status");

        // R8: power-down bit and pin
        reg_write(8'h02, '{8'h20}, 1'b0);
        chk(pd_o == 1'b1, "R8 pd bit", 32'(pd_o), 32'd1);
        reg_write(8'h02, '{8'h00}, 1'b0);
        pd_pin = 1'b1;
        tick(2);
        chk(pd_o == 1'b1, "R8 pd pin", 32'(pd_o), 32'd1);
        reg_write(8'h03, '{8'h11}, 1'b0);
        reg_read_chk(8'h03, 1, "R8 access in power-down");
        pd_pin = 1'b0;
        tick(2);

        // R7: self-clearing reset request
        reg_write(8'h02, '{8'h10}, 1'b0);
        chk(core_rst_o == 1'b1, "R7 reset set", 32'(core_rst_o), 32'd1);
        tick(5);
        chk(core_rst_o == 1'b1, "R7 reset held", 32'(core_rst_o), 32'd1);
        rst_done = 1'b1; tick(1);
        rst_done = 1'b0;
        mctrl[4] = 1'b0;
        chk(core_rst_o == 1'b0, "R7 reset self-clear", 32'(core_rst_o), 32'd0);
        reg_read_chk(8'h02, 1, "R7 control readback");

        // R10: counter windows and clear strobes
        cnt = 24'hC3B2A1;
        for (int i = 0; i < 3; i++) clr_seen[i] = 0;
        reg_read_chk(8'h05, 3, "R10 counter read");
        for (int i = 0; i < 3; i++) begin
            chk(clr_seen[i] == 1, "R10 one strobe per read", 32'(clr_seen[i]), 32'd1);
        end
        for (int i = 0; i < 3; i++) clr_seen[i] = 0;
        reg_read_chk(8'h06, 1, "R10 single counter read");
        chk(clr_seen[0] == 0 && clr_seen[1] == 1 && clr_seen[2] == 0, "R10 strobe selects",
            32'({clr_seen[2][3:0], clr_seen[1][3:0], clr_seen[0][3:0]}), 32'h010);

        // R12: out-of-range address
        reg_write(8'h40, '{8'h77}, 1'b0);
        reg_read_chk(8'h40, 1, "R12 out of range reads zero");

        // R6: short glitches on SCL and SDA are filtered
        reg_write(8'h04, '{8'h5A}, 1'b1);
        chk(cfg_o == 16'h5A11, "R6 glitch filtered", 32'(cfg_o), 32'h5A11);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule